// File: doc/BRIEF.md
# Programmable-Register Access Sequencer for a Synchronous FIFO

This block sits next to a synchronous FIFO whose data ports double as the path for loading and reading back its threshold and control settings. A load strobe (`ld_n_i`, active low) chooses between two kinds of access. While it is low, a qualified write enable stores input data into a settings register. While it is low, a qualified read enable copies a settings register onto the data output. While it is high, the same enables turn into FIFO memory write and read strobes for the storage array next to the block.

Two pointers pick the register that the next settings access reaches. One pointer lives in the write-clock domain and one in the read-clock domain, and they step independently. In compatible mode a pointer alternates between the almost-empty offset (word 0) and the almost-full offset (word 1). In enhanced mode it also visits a control word (word 2) before it returns to word 0. Two control bits affect the access logic. Control bit 0 arms a re-home of a pointer: after the load strobe is released, the next memory cycle on that side sends the pointer back to word 0. Control bit 5 makes each side qualify its enable with a second enable, and on the read side also with the output enable.

Top module: `prs_top`

## Requirements
- R1: After reset, both pointers point at word 0, the almost-empty and almost-full offsets hold 12'd8, the control word is zero, and `dout_o` passes `mem_rdata_i` through.
- R2: With `emode_i` low, successive settings accesses on one side visit word 0, word 1, word 0, word 1 and so on. Word 2 is never reached.
- R3: With `emode_i` high, successive settings accesses on one side visit word 0, word 1, word 2 and then word 0 again.
- R4: On a clock edge where `ld_n_i` is low and that side's enable is not qualified, that side's pointer holds and no register is written.
- R5: On an edge where `ld_n_i` is high and the enable is qualified, `fifo_we_o` (write side) or `fifo_re_o` (read side) is high. When `ld_n_i` is low, or the enable is not qualified, the strobe is low. Both strobes are combinational from the inputs.
- R6: A settings write stores `din_i[11:0]` into an offset word, or all 18 bits into the control word. When an offset word is read back, bits 17:12 are zero.
- R7: After a settings read edge, `dout_o` holds the selected word until the next read-side access. After a memory read edge, `dout_o` follows `mem_rdata_i`.
- R8: With `emode_i` high and control bit 0 set, a 0-to-1 transition of `ld_n_i` seen on the write clock, followed by a memory write, returns the write pointer to word 0.
- R9: Under the same conditions, a 0-to-1 transition of `ld_n_i` seen on the read clock, followed by a memory read, returns the read pointer to word 0.
- R10: With `emode_i` high and control bit 5 set, a write is qualified only when both `wen_n_i` and `wen2_n_i` are low. A read is qualified only when `ren_n_i`, `ren2_n_i` and `oe_n_i` are all low. Otherwise only `wen_n_i` or `ren_n_i` is needed.
- R11: Settings accesses on one side never move the other side's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| emode_i | input | 1 | High selects the three-word enhanced sequence |
| ld_n_i | input | 1 | Low selects settings access, high selects memory access |
| wen_n_i | input | 1 | Write enable, active low |
| wen2_n_i | input | 1 | Second write enable, active low, used when gating is on |
| ren_n_i | input | 1 | Read enable, active low |
| ren2_n_i | input | 1 | Second read enable, active low, used when gating is on |
| oe_n_i | input | 1 | Output enable, active low, used in read qualification when gating is on |
| din_i | input | 18 | Write data |
| mem_rdata_i | input | 18 | Data from the FIFO storage array |
| dout_o | output | 18 | Output data: a settings word or the memory data |
| fifo_we_o | output | 1 | Memory write strobe for the current write clock edge |
| fifo_re_o | output | 1 | Memory read strobe for the current read clock edge |

## Verification
The memory strobes are combinational, so the bench samples them 1 ns after it drives the inputs, before the edge that uses them. The pointers, the stored words and the output register all change at the rising edge. The bench therefore samples `dout_o` at the next falling edge and compares it with a model that it updates at that same edge. Pointer position is not a port, so each pointer is checked through the word that the next settings read returns. Re-home and gating cases are first run as directed sequences from a fresh reset, and then constrained-random traffic changes the control bits while it runs.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef logic [1:0] word_sel_t;
  localparam word_sel_t SEL_AE   = 2'd0;
  localparam word_sel_t SEL_AF   = 2'd1;
  localparam word_sel_t SEL_CTRL = 2'd2;

  localparam int unsigned CTRL_REHOME_BIT = 0;
  localparam int unsigned CTRL_GATE_BIT   = 5;

  function automatic word_sel_t next_sel(input word_sel_t cur, input logic enh);
    word_sel_t last;
    last = enh ? SEL_CTRL : SEL_AF;
    return (cur >= last) ? SEL_AE : word_sel_t'(cur + 2'd1);
  endfunction
endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/prs_sel_ptr.sv
module prs_sel_ptr
  import prs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_n,
  input  logic      qual,
  input  logic      enh,
  input  logic      rehome_en,
  output word_sel_t sel_o,
  output logic      reg_acc_o,
  output logic      mem_acc_o
);
  word_sel_t sel_q, sel_d;
  logic      sel_en;
  logic      ld_q;
  logic      pend_q, pend_d;
  logic      rise, pend_eff, rehome;

  assign reg_acc_o = ~ld_n & qual;
  assign mem_acc_o = ld_n & qual;
  assign rise      = ld_n & ~ld_q;
  assign pend_eff  = pend_q | rise;
  assign rehome    = mem_acc_o & pend_eff & enh & rehome_en;

  always_comb begin
    sel_d  = sel_q;
    sel_en = 1'b0;
    if (reg_acc_o) begin
      sel_d  = next_sel(sel_q, enh);
      sel_en = 1'b1;
    end else if (rehome) begin
      sel_d  = SEL_AE;
      sel_en = 1'b1;
    end
    if (!ld_n)          pend_d = 1'b0;
    else if (mem_acc_o) pend_d = 1'b0;
    else                pend_d = pend_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_AE;
      ld_q   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      ld_q   <= ld_n;
      pend_q <= pend_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != 2'd3); // R3
  AST_HOLD_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !qual) |=> $stable(sel_q)); // R4
  AST_COMPAT_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_acc_o && !enh && sel_q == SEL_AE) |=> sel_q == SEL_AF); // R2
  AST_ENH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_acc_o && enh && sel_q == SEL_CTRL) |=> sel_q == SEL_AE); // R3
  AST_REHOME_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_acc_o && pend_q && enh && rehome_en) |=> sel_q == SEL_AE); // R8
endmodule

// File: rtl/prs_reg_bank.sv
module prs_reg_bank
  import prs_pkg::*;
#(
  parameter int unsigned DW     = 18,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned AE_RST = 8,
  parameter int unsigned AF_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  word_sel_t        sel,
  input  logic [DW-1:0]    din,
  output logic [OFS_W-1:0] ae_o,
  output logic [OFS_W-1:0] af_o,
  output logic [DW-1:0]    ctrl_o
);
  logic [OFS_W-1:0] ae_q, af_q;
  logic [DW-1:0]    ctrl_q;
  logic             ae_en, af_en, ctrl_en;

  always_comb begin
    ae_en   = we && (sel == SEL_AE);
    af_en   = we && (sel == SEL_AF);
    ctrl_en = we && (sel == SEL_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q   <= OFS_W'(AE_RST);
      af_q   <= OFS_W'(AF_RST);
      ctrl_q <= '0;
    end else begin
      if (ae_en)   ae_q   <= din[OFS_W-1:0];
      if (af_en)   af_q   <= din[OFS_W-1:0];
      if (ctrl_en) ctrl_q <= din;
    end
  end

  assign ae_o   = ae_q;
  assign af_o   = af_q;
  assign ctrl_o = ctrl_q;

  AST_AE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_AE) |=> ae_q == $past(din[OFS_W-1:0])); // R6
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_CTRL) |=> ctrl_q == $past(din)); // R6
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(ae_q) && $stable(af_q) && $stable(ctrl_q))); // R4
endmodule

// File: rtl/prs_rd_port.sv
module prs_rd_port
  import prs_pkg::*;
#(
  parameter int unsigned DW    = 18,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             mem_rd,
  input  word_sel_t        sel,
  input  logic [OFS_W-1:0] ae,
  input  logic [OFS_W-1:0] af,
  input  logic [DW-1:0]    ctrl,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    dout
);
  logic [DW-1:0] pick, hold_q;
  logic          show_q, show_d;

  always_comb begin
    case (sel)
      SEL_AE:   pick = DW'(ae);
      SEL_AF:   pick = DW'(af);
      SEL_CTRL: pick = ctrl;
      default:  pick = '0;
    endcase
    if (reg_rd)      show_d = 1'b1;
    else if (mem_rd) show_d = 1'b0;
    else             show_d = show_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_q <= 1'b0;
      hold_q <= '0;
    end else begin
      show_q <= show_d;
      if (reg_rd) hold_q <= pick;
    end
  end

  assign dout = show_q ? hold_q : mem_rdata;

  AST_MEM_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> dout == mem_rdata); // R7
  AST_OFFSET_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel != SEL_CTRL) |=> dout[DW-1:OFS_W] == '0); // R6
endmodule

// File: rtl/prs_top.sv
module prs_top
  import prs_pkg::*;
#(
  parameter int unsigned DW     = 18,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned AE_RST = 8,
  parameter int unsigned AF_RST = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          emode_i,
  input  logic          ld_n_i,
  input  logic          wen_n_i,
  input  logic          wen2_n_i,
  input  logic          ren_n_i,
  input  logic          ren2_n_i,
  input  logic          oe_n_i,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] dout_o,
  output logic          fifo_we_o,
  output logic          fifo_re_o
);
  logic             w_srst_n, r_srst_n;
  logic             gate, w_qual, r_qual;
  logic             w_reg, w_mem, r_reg, r_mem;
  word_sel_t        w_sel, r_sel;
  logic [OFS_W-1:0] ae, af;
  logic [DW-1:0]    ctrl;

  prs_rst_sync #(.STAGES(2)) u_wrst (.clk(wclk), .rst_n(rst_n), .srst_n_o(w_srst_n));
  prs_rst_sync #(.STAGES(2)) u_rrst (.clk(rclk), .rst_n(rst_n), .srst_n_o(r_srst_n));

  always_comb begin
    gate   = emode_i & ctrl[CTRL_GATE_BIT];
    w_qual = w_srst_n & ~wen_n_i & (~gate | ~wen2_n_i);
    r_qual = r_srst_n & ~ren_n_i & (~gate | (~ren2_n_i & ~oe_n_i));
  end

  prs_sel_ptr u_wptr (
    .clk(wclk), .rst_n(w_srst_n), .ld_n(ld_n_i), .qual(w_qual), .enh(emode_i),
    .rehome_en(ctrl[CTRL_REHOME_BIT]), .sel_o(w_sel), .reg_acc_o(w_reg), .mem_acc_o(w_mem)
  );

  prs_sel_ptr u_rptr (
    .clk(rclk), .rst_n(r_srst_n), .ld_n(ld_n_i), .qual(r_qual), .enh(emode_i),
    .rehome_en(ctrl[CTRL_REHOME_BIT]), .sel_o(r_sel), .reg_acc_o(r_reg), .mem_acc_o(r_mem)
  );

  prs_reg_bank #(.DW(DW), .OFS_W(OFS_W), .AE_RST(AE_RST), .AF_RST(AF_RST)) u_bank (
    .clk(wclk), .rst_n(w_srst_n), .we(w_reg), .sel(w_sel), .din(din_i),
    .ae_o(ae), .af_o(af), .ctrl_o(ctrl)
  );

  prs_rd_port #(.DW(DW), .OFS_W(OFS_W)) u_rdp (
    .clk(rclk), .rst_n(r_srst_n), .reg_rd(r_reg), .mem_rd(r_mem), .sel(r_sel),
    .ae(ae), .af(af), .ctrl(ctrl), .mem_rdata(mem_rdata_i), .dout(dout_o)
  );

  assign fifo_we_o = w_mem;
  assign fifo_re_o = r_mem;

  AST_NO_MEMWR_IN_LOAD: assert property (@(posedge wclk) disable iff (!w_srst_n)
    !ld_n_i |-> !fifo_we_o); // R5
  AST_NO_MEMRD_IN_LOAD: assert property (@(posedge rclk) disable iff (!r_srst_n)
    !ld_n_i |-> !fifo_re_o); // R5
  AST_GATED_READ_OE: assert property (@(posedge rclk) disable iff (!r_srst_n)
    (emode_i && ctrl[CTRL_GATE_BIT] && oe_n_i) |-> !fifo_re_o); // R10
  AST_GATED_WRITE_EN2: assert property (@(posedge wclk) disable iff (!w_srst_n)
    (emode_i && ctrl[CTRL_GATE_BIT] && wen2_n_i) |-> !fifo_we_o); // R10
endmodule

// File: tb/prs_top_bench.sv
module prs_top_bench;
  logic        clk = 1'b0;
  logic        rst_n, emode, ld_n, wen_n, wen2_n, ren_n, ren2_n, oe_n;
  logic [17:0] din, mrd, dout;
  logic        fwe, fre;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;

  logic [11:0] m_ae, m_af;
  logic [17:0] m_ctrl, m_hold;
  int          m_wp, m_rp;
  logic        m_wld, m_rld, m_wpend, m_rpend, m_show;

  always #2 clk = ~clk;

  prs_top u_prs_top (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .emode_i(emode), .ld_n_i(ld_n),
    .wen_n_i(wen_n), .wen2_n_i(wen2_n), .ren_n_i(ren_n), .ren2_n_i(ren2_n), .oe_n_i(oe_n),
    .din_i(din), .mem_rdata_i(mrd), .dout_o(dout), .fifo_we_o(fwe), .fifo_re_o(fre)
  );

  function automatic int nxt(input int p, input logic em);
    int last = em ? 2 : 1;
    return (p >= last) ? 0 : p + 1;
  endfunction

  function automatic logic [17:0] pick(input int p);
    case (p)
      0: return {6'd0, m_ae};
      1: return {6'd0, m_af};
      default: return m_ctrl;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc_cnt);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    ld_n = 1; wen_n = 1; wen2_n = 1; ren_n = 1; ren2_n = 1; oe_n = 1; din = '0; mrd = 18'h15a5a;
    rst_n = 0;
    m_ae = 12'd8; m_af = 12'd8; m_ctrl = '0; m_hold = '0;
    m_wp = 0; m_rp = 0; m_wld = 1; m_rld = 1; m_wpend = 0; m_rpend = 0; m_show = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "dout after reset", dout, mrd);
  endtask

  task automatic cyc(input logic ld, input logic we, input logic we2, input logic re,
                     input logic re2, input logic oe, input logic [17:0] d,
                     input logic [17:0] m, input string tag);
    logic gate, wq, rq, wpe, rpe;
    logic [11:0] n_ae, n_af;
    logic [17:0] n_ctrl;
    ld_n = ld; wen_n = we; wen2_n = we2; ren_n = re; ren2_n = re2; oe_n = oe; din = d; mrd = m;
    #1;
    gate = emode && m_ctrl[5];
    wq = !we && (!gate || !we2);
    rq = !re && (!gate || (!re2 && !oe));
    chk(gate ? "R10" : "R5", "fifo_we", {17'd0, fwe}, {17'd0, ld && wq});
    chk(gate ? "R10" : "R5", "fifo_re", {17'd0, fre}, {17'd0, ld && rq});
    @(posedge clk);
    n_ae = m_ae; n_af = m_af; n_ctrl = m_ctrl;
    wpe = m_wpend || (ld && !m_wld);
    rpe = m_rpend || (ld && !m_rld);
    if (!ld && wq) begin
      if (m_wp == 0) n_ae = d[11:0];
      else if (m_wp == 1) n_af = d[11:0];
      else n_ctrl = d;
      m_wp = nxt(m_wp, emode);
    end else if (ld && wq && wpe && emode && m_ctrl[0]) m_wp = 0;
    m_wpend = !ld ? 1'b0 : (wq ? 1'b0 : wpe);
    m_wld = ld;
    if (!ld && rq) begin
      m_show = 1; m_hold = pick(m_rp);
      m_rp = nxt(m_rp, emode);
    end else if (ld && rq) begin
      m_show = 0;
      if (rpe && emode && m_ctrl[0]) m_rp = 0;
    end
    m_rpend = !ld ? 1'b0 : (rq ? 1'b0 : rpe);
    m_rld = ld;
    m_ae = n_ae; m_af = n_af; m_ctrl = n_ctrl;
    @(negedge clk);
    chk(tag, "dout", dout, m_show ? m_hold : mrd);
  endtask

  task automatic wr(input logic [17:0] d, input string tag);
    cyc(0, 0, 0, 1, 1, 1, d, 18'h0, tag);
  endtask
  task automatic rd(input string tag);
    cyc(0, 1, 1, 0, 0, 0, 18'h0, 18'h2abcd, tag);
  endtask

  task automatic rnd(input int n, input string tag, input int ld_bias);
    for (int i = 0; i < n; i++) begin
      cyc(($urandom % 100) < ld_bias, $urandom % 2, $urandom % 2, $urandom % 2,
          $urandom % 2, ($urandom % 4) == 0, 18'($urandom), 18'($urandom), tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    emode = 0;
    do_reset();
    rd("R1"); rd("R1"); rd("R1");

    do_reset();
    wr(18'h3fabc, "R6"); wr(18'h2f123, "R6");
    rd("R6"); rd("R6"); rd("R2"); rd("R2");

    do_reset();
    cyc(0, 1, 1, 1, 1, 1, 18'h00777, 18'h0, "R4");
    cyc(0, 1, 1, 1, 1, 1, 18'h00666, 18'h0, "R4");
    wr(18'h00345, "R4"); rd("R4"); rd("R4");

    do_reset(); emode = 1;
    wr(18'h00011, "R3"); wr(18'h00022, "R3"); wr(18'h3c000, "R3");
    rd("R3"); rd("R3"); rd("R3"); rd("R3");
    cyc(1, 1, 1, 0, 1, 1, 18'h0, 18'h11111, "R7");
    cyc(1, 1, 1, 1, 1, 1, 18'h0, 18'h22222, "R7");

    do_reset(); emode = 1;
    wr(18'h005, "R8"); wr(18'h006, "R8"); wr(18'h001, "R8"); wr(18'h011, "R8");
    cyc(1, 1, 1, 1, 1, 1, 18'h0, 18'h0, "R8");
    cyc(1, 0, 1, 1, 1, 1, 18'h0, 18'h0, "R8");
    wr(18'h022, "R8");
    rd("R8"); rd("R8");

    do_reset(); emode = 1;
    wr(18'h00a, "R9"); wr(18'h00b, "R9"); wr(18'h001, "R9");
    rd("R9");
    cyc(1, 1, 1, 1, 1, 1, 18'h0, 18'h0, "R9");
    cyc(1, 1, 1, 0, 0, 0, 18'h0, 18'h13579, "R9");
    rd("R9");

    do_reset(); emode = 1;
    wr(18'h001, "R10"); wr(18'h002, "R10"); wr(18'h020, "R10");
    cyc(1, 1, 1, 0, 0, 1, 18'h0, 18'h0, "R10");
    cyc(0, 1, 1, 0, 1, 0, 18'h0, 18'h0, "R10");
    cyc(0, 0, 1, 1, 1, 1, 18'h3ffff, 18'h0, "R10");
    rd("R10"); rd("R10");
    rnd(500, "R10", 50);

    do_reset(); emode = 0; rnd(3000, "R2", 50);
    do_reset(); emode = 1; rnd(3000, "R11", 50);
    do_reset(); emode = 1; rnd(2000, "R7", 80);
    summary();
  end
endmodule